// File: doc/BRIEF.md
# Instruction Step Countdown Halt Unit

This block lets a debug host stop a processor after a chosen number of executed instructions. The host writes a step count and arms trace mode with one load pulse. From then on the core pulses `retire` once for each completed instruction. Each pulse lowers the counter by one until it reaches zero. The next pulse after that raises a held halt request toward the core. It also sets a sticky status flag so the host can tell a countdown halt from a halt with any other cause.

A load of N therefore lets N+1 instructions complete, and the request follows the last of them. The normal minimum load is one, which gives two instructions. When the sequential-breakpoint mode input is high, a load of zero is also accepted and stops the core after exactly one instruction. A zero load outside that mode is refused: it raises a configuration error flag and leaves trace mode disarmed. When the core acknowledges debug entry, the request drops and trace mode disarms until the host loads again. Retire pulses that arrive while the core reports it is in debug mode do nothing.

Top module: `trace_countdown`

## Requirements
- R1: After reset, `halt_req`, `trace_hit`, `cfg_err` and `armed` are 0 and `count_q` is 0.
- R2: A `cfg_load` pulse with a nonzero `cfg_count` sets `armed` to 1, sets `count_q` to `cfg_count` and clears `cfg_err`, all visible in the cycle after the pulse.
- R3: A `retire` pulse lowers `count_q` by exactly one when four conditions hold: `armed` is 1, `count_q` is nonzero, `in_debug` is 0 and `halt_req` is 0. `halt_req` stays 0 after such a pulse.
- R4: A qualifying `retire` pulse while `count_q` is 0 sets `halt_req` in the following cycle. After a load of N, the request therefore appears after retire pulse N+1 and not earlier.
- R5: Once set, `halt_req` stays 1 until `dbg_ack` is 1. Retire pulses while it is set leave `count_q` unchanged.
- R6: `trace_hit` is set together with a countdown halt request. It stays 1 until a `trace_clr` pulse. If a set and a clear fall in the same cycle, the set wins.
- R7: With `seq_mode` at 1, a load of 0 is accepted (`armed` 1, `cfg_err` 0), and the first retire pulse raises `halt_req`.
- R8: With `seq_mode` at 0, a load of 0 sets `cfg_err` to 1 and leaves `armed` at 0. Later retire pulses raise no request.
- R9: `dbg_ack` clears `halt_req` and `armed` in the following cycle unless a load is accepted in the same cycle.
- R10: Retire pulses while `in_debug` is 1 leave `count_q` and `halt_req` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Host pulse: load count and arm trace mode |
| cfg_count | input | CNT_W | Step count to load |
| seq_mode | input | 1 | Sequential-breakpoint mode, allows a zero load |
| trace_clr | input | 1 | Host pulse clearing the sticky trace status |
| retire | input | 1 | One-cycle pulse per completed instruction |
| in_debug | input | 1 | Core is already in debug mode |
| dbg_ack | input | 1 | Core acknowledges debug entry |
| halt_req | output | 1 | Held request to enter debug mode |
| trace_hit | output | 1 | Sticky flag: halt came from the countdown |
| cfg_err | output | 1 | Zero load refused outside sequential mode |
| armed | output | 1 | Trace mode active |
| count_q | output | CNT_W | Current countdown value |

## Verification
The bench builds the block with `CNT_W` set to 8, so the largest count of 255 can be counted out in full within the run. It tests randomized loads from 1 to 40 and a directed full-scale load. Each load has random idle gaps between retire pulses. These runs confirm that the request follows retire pulse N+1 and that the register holds at the all-zero boundary. The narrow width also makes the zero-load cases cheap to reach in both modes, together with acknowledge, clear and in-debug masking.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    CFG_NONE   = 2'd0,
    CFG_ACCEPT = 2'd1,
    CFG_REJECT = 2'd2
  } cfg_verdict_e;
endpackage

// File: rtl/tc_cfg_check.sv
module tc_cfg_check
  import tc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic             seq_mode,
  output cfg_verdict_e     verdict
);
  logic is_zero;

  always_comb begin
    is_zero = (count == '0);
    verdict = CFG_NONE;
    if (load) begin
      if (is_zero && !seq_mode) verdict = CFG_REJECT;
      else                      verdict = CFG_ACCEPT;
    end
  end
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_en | dec_en;
    cnt_d  = cnt;
    if (load_en)     cnt_d = load_val;
    else if (dec_en) cnt_d = cnt - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign cnt_zero = (cnt == '0);
endmodule

// File: rtl/tc_status.sv
module tc_status
  import tc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  cfg_verdict_e verdict,
  input  logic         fire,
  input  logic         ack,
  input  logic         clr_hit,
  output logic         armed,
  output logic         halt_req,
  output logic         hit,
  output logic         err
);
  logic armed_d, halt_d, hit_d, err_d;
  logic accept, reject;

  always_comb begin
    accept  = (verdict == CFG_ACCEPT);
    reject  = (verdict == CFG_REJECT);
    armed_d = armed;
    if (accept)              armed_d = 1'b1;
    else if (reject || ack)  armed_d = 1'b0;
    halt_d  = (halt_req & ~ack) | fire;
    hit_d   = (hit & ~clr_hit) | fire;
    err_d   = err;
    if (reject)      err_d = 1'b1;
    else if (accept) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      halt_req <= 1'b0;
      hit      <= 1'b0;
      err      <= 1'b0;
    end else begin
      armed    <= armed_d;
      halt_req <= halt_d;
      hit      <= hit_d;
      err      <= err_d;
    end
  end
endmodule

// File: rtl/trace_countdown.sv
module trace_countdown
  import tc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             seq_mode,
  input  logic             trace_clr,
  input  logic             retire,
  input  logic             in_debug,
  input  logic             dbg_ack,
  output logic             halt_req,
  output logic             trace_hit,
  output logic             cfg_err,
  output logic             armed,
  output logic [CNT_W-1:0] count_q
);
  cfg_verdict_e verdict;
  logic         step, fire, dec, cnt_zero, load_ok;

  tc_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .load     (cfg_load),
    .count    (cfg_count),
    .seq_mode (seq_mode),
    .verdict  (verdict)
  );

  always_comb begin
    load_ok = (verdict == CFG_ACCEPT);
    step    = armed & retire & ~in_debug & ~halt_req & ~cfg_load;
    fire    = step & cnt_zero;
    dec     = step & ~cnt_zero;
  end

  tc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_ok),
    .load_val (cfg_count),
    .dec_en   (dec),
    .cnt      (count_q),
    .cnt_zero (cnt_zero)
  );

  tc_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .verdict  (verdict),
    .fire     (fire),
    .ack      (dbg_ack),
    .clr_hit  (trace_clr),
    .armed    (armed),
    .halt_req (halt_req),
    .hit      (trace_hit),
    .err      (cfg_err)
  );
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic [CNT_W-1:0] cfg_count,
  input logic             seq_mode,
  input logic             trace_clr,
  input logic             retire,
  input logic             in_debug,
  input logic             dbg_ack,
  input logic             halt_req,
  input logic             trace_hit,
  input logic             cfg_err,
  input logic             armed,
  input logic [CNT_W-1:0] count_q
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && (cfg_count != '0) |=> armed && !cfg_err && count_q == $past(cfg_count));

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && retire && !in_debug && !halt_req && !cfg_load && count_q != '0
    |=> count_q == $past(count_q) - 1'b1);

  assert_req_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(armed && retire && count_q == '0 && !in_debug));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && !dbg_ack |=> halt_req);

  assert_pending_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && !cfg_load |=> $stable(count_q));

  assert_hit_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trace_hit && !trace_clr |=> trace_hit);

  assert_hit_with_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> trace_hit);

  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && cfg_count == '0 && !seq_mode |=> cfg_err && !armed);

  assert_seq_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && cfg_count == '0 && seq_mode |=> armed && !cfg_err);

  assert_ack_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ack && !cfg_load |=> !armed && !halt_req);

  assert_in_debug_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug && !cfg_load |=> $stable(count_q));
endmodule

bind trace_countdown tc_checker #(.CNT_W(CNT_W)) u_tc_checker (.*);

// File: tb/trace_countdown_bench.sv
module trace_countdown_bench;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_load, seq_mode, trace_clr, retire, in_debug, dbg_ack;
  logic [CNT_W-1:0] cfg_count;
  logic             halt_req, trace_hit, cfg_err, armed;
  logic [CNT_W-1:0] count_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  trace_countdown #(.CNT_W(CNT_W)) u_trace_countdown (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_count(cfg_count),
    .seq_mode(seq_mode), .trace_clr(trace_clr), .retire(retire),
    .in_debug(in_debug), .dbg_ack(dbg_ack), .halt_req(halt_req),
    .trace_hit(trace_hit), .cfg_err(cfg_err), .armed(armed), .count_q(count_q)
  );

  function automatic int exp_left(int n, int done_steps);
    return n - done_steps;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic load(int n, bit seq);
    cfg_load = 1; cfg_count = CNT_W'(n); seq_mode = seq;
    cyc();
    cfg_load = 0;
  endtask

  task automatic pulse_retire();
    retire = 1; cyc(); retire = 0;
  endtask

  task automatic ack_and_clear();
    dbg_ack = 1; cyc(); dbg_ack = 0;
    chk(!halt_req && !armed, "R9 ack clears request and arm", int'(halt_req), 0);
    trace_clr = 1; cyc(); trace_clr = 0;
    chk(!trace_hit, "R6 clear drops trace_hit", int'(trace_hit), 0);
  endtask

  task automatic run_trace(int n, bit gaps);
    bit early = 0;
    load(n, 1'b0);
    chk(armed && !cfg_err, "R2 armed after load", int'(armed), 1);
    chk(int'(count_q) == n, "R2 loaded count", int'(count_q), n);
    for (int i = 1; i <= n; i++) begin
      if (gaps) idle(int'($urandom % 3));
      pulse_retire();
      if (halt_req) early = 1;
      if (int'(count_q) != exp_left(n, i))
        chk(0, "R3 decrement", int'(count_q), exp_left(n, i));
    end
    chk(!early, "R4 no request before pulse N+1", int'(early), 0);
    chk(count_q == '0, "R3 counted to zero", int'(count_q), 0);
    pulse_retire();
    chk(halt_req, "R4 request after pulse N+1", int'(halt_req), 1);
    chk(trace_hit, "R6 trace_hit set with request", int'(trace_hit), 1);
    pulse_retire();
    idle(2);
    chk(halt_req && count_q == '0, "R5 request held, count still", int'(count_q), 0);
    ack_and_clear();
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; cfg_load = 0; cfg_count = '0; seq_mode = 0; trace_clr = 0;
    retire = 0; in_debug = 0; dbg_ack = 0;
    idle(3);
    rst_n = 1;
    cyc();
    chk(!halt_req && !trace_hit && !cfg_err && !armed && count_q == '0,
        "R1 reset state", int'(count_q), 0);

    run_trace(1, 1'b0);
    run_trace(255, 1'b0);
    for (int k = 0; k < 12; k++) run_trace(1 + int'($urandom % 40), 1'b1);

    // R7 zero load in sequential mode
    load(0, 1'b1);
    chk(armed && !cfg_err, "R7 zero accepted in seq mode", int'(cfg_err), 0);
    pulse_retire();
    chk(halt_req, "R7 request after first pulse", int'(halt_req), 1);
    ack_and_clear();

    // R8 zero load outside sequential mode
    load(0, 1'b0);
    chk(cfg_err && !armed, "R8 zero refused", int'(cfg_err), 1);
    pulse_retire(); pulse_retire();
    chk(!halt_req && !trace_hit, "R8 no request when refused", int'(halt_req), 0);
    load(3, 1'b0);
    chk(!cfg_err, "R2 error cleared by good load", int'(cfg_err), 0);

    // R10 retires while in debug are ignored
    in_debug = 1;
    pulse_retire(); pulse_retire(); pulse_retire(); pulse_retire();
    in_debug = 0;
    chk(int'(count_q) == 3 && !halt_req, "R10 in-debug retires ignored", int'(count_q), 3);

    // R6 set wins over clear in same cycle
    pulse_retire(); pulse_retire(); pulse_retire();
    retire = 1; trace_clr = 1; cyc(); retire = 0; trace_clr = 0;
    chk(trace_hit && halt_req, "R6 set wins over clear", int'(trace_hit), 1);

    // R9 ack disarms: later retires do nothing
    dbg_ack = 1; cyc(); dbg_ack = 0;
    trace_clr = 1; cyc(); trace_clr = 0;
    pulse_retire(); pulse_retire();
    chk(!halt_req && !armed, "R9 disarmed after ack", int'(armed), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule